// File: doc/BRIEF.md
# Exception Context Save and Restore Sequencer

This block sits beside the pipeline of a small 32-bit core and takes over the work of saving and restoring the interrupted context. When an exception is requested, it builds an eight-word frame on whichever stack is active. The frame holds general registers 0 to 3, general register 12, the link register, the address of the next instruction and the status word. It then loads the link register with a marker value and fetches the handler address from a vector table. The core stalls while `busy` is high.

The block watches every program-counter write the core makes. An ordinary value is passed through as a branch. A marker value is never branched to. Instead, the block reads the frame back from the stack the marker names and refills the registers. It then hands the saved next-instruction address back with a one-cycle done pulse. If another exception is already waiting when a marker is written, the frame stays where it is and the block goes straight to the new handler's vector.

Top module: `exc_seq`

## Requirements
- R1: During and after reset `busy`, `mem_req` and every pulse output are low until an exception or a marker write arrives.
- R2: On entry, eight words are written to addresses base, base+4, …, base+28, where base is the active stack pointer minus 32. The active stack is the process stack only when `on_psp`=1 and `in_handler`=0. The words are, in rising address order: registers 0, 1, 2, 3, 12, 14 (link register), `cur_pc`, `cur_psr`.
- R3: Exactly one word moves per cycle in which `mem_req` and `mem_ready` are both high. While `mem_ready` is low, address, direction and write data hold.
- R4: After the last push, the selected stack pointer is written with base (`sp_sel`: 0 = main, 1 = process). In the same cycle register 14 is written with the marker: 0xFFFFFFF1 if entered from handler mode, 0xFFFFFFF9 from thread mode on the main stack, 0xFFFFFFFD from thread mode on the process stack.
- R5: After the frame, one read is made at `VT_BASE + 4*exc_num`. `vec_valid` pulses for one cycle with `vec_pc` equal to the word read.
- R6: A program-counter write whose bits 31:5 are all ones is a marker and gives `branch_take`=0. Any other value gives `branch_take`=1 in the same cycle with no memory activity.
- R7: A valid marker with no exception waiting starts eight reads from the stack pointer that marker bit 2 selects (1 = process). Words 0 to 5 are written back to registers 0, 1, 2, 3, 12 and 14.
- R8: On the eighth read, `ret_valid` pulses. `ret_pc` equals word 6 and `ret_psr` equals word 7. `ret_handler` is 1 only for 0xFFFFFFF1 and `ret_psp` is 1 only for 0xFFFFFFFD. The selected stack pointer is written with its old value plus 32.
- R9: A marker whose low five bits are none of 0x11, 0x19, 0x1D pulses `ret_err` in that cycle and starts no memory access.
- R10: A valid marker written while `exc_req` is high skips the restore. The next and only access is the vector read for the new `exc_num`. Register 14 is rewritten with the same marker, no stack pointer is written, and the frame stays in memory for a later return.
- R11: `busy` is high exactly while a push, a vector read or a restore is in progress. It is low in the cycle after the final handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception waiting to be taken |
| exc_num | input | NUM_W | Number of the waiting exception |
| in_handler | input | 1 | Core currently in handler mode |
| on_psp | input | 1 | Core currently using the process stack |
| msp | input | 32 | Main stack pointer value |
| psp | input | 32 | Process stack pointer value |
| cur_pc | input | 32 | Address of the next instruction at entry |
| cur_psr | input | 32 | Status word at entry |
| pc_wr_valid | input | 1 | Core writes the program counter this cycle |
| pc_wr_data | input | 32 | Value written to the program counter |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| sp_we | output | 1 | Stack pointer update |
| sp_sel | output | 1 | Stack pointer being updated: 0 main, 1 process |
| sp_wdata | output | 32 | New stack pointer value |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| busy | output | 1 | Stall request to the pipeline |
| branch_take | output | 1 | Program-counter write is an ordinary branch |
| ret_err | output | 1 | Marker with an unsupported low pattern |
| vec_valid | output | 1 | Handler address ready |
| vec_pc | output | 32 | Handler address |
| ret_valid | output | 1 | Context restore finished |
| ret_pc | output | 32 | Address to resume at |
| ret_psr | output | 32 | Restored status word |
| ret_handler | output | 1 | Resume in handler mode |
| ret_psp | output | 1 | Resume on the process stack |

## Verification
A wrong beat counter or base register shows up on the memory port in the very next handshake. It appears as a misplaced or reordered frame word, which a read-back of the stack area catches right after entry. A corrupted marker decode or stack selector only surfaces at the return: registers come back from the wrong stack, or `ret_pc` and the stack pointer carry wrong values in the single cycle of the done pulse. A broken skip path for a waiting exception is visible at once as extra memory handshakes before the vector pulse, and as a disturbed stack pointer.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int FRAME_WORDS = 8;
  localparam int IDX_W       = $clog2(FRAME_WORDS);
  localparam int FRAME_BYTES = FRAME_WORDS * 4;
  localparam logic [3:0]  LR_IDX  = 4'd14;
  localparam logic [31:0] MK_HDL  = 32'hFFFF_FFF1;
  localparam logic [31:0] MK_THRM = 32'hFFFF_FFF9;
  localparam logic [31:0] MK_THRP = 32'hFFFF_FFFD;

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_VEC, ST_POP} seq_state_t;

  // Frame slot to register index: slots 0..3 direct, 4 -> 12, 5 -> link.
  function automatic logic [3:0] frame_reg(input logic [IDX_W-1:0] slot);
    case (slot)
      IDX_W'(4): return 4'd12;
      IDX_W'(5): return LR_IDX;
      default:   return 4'(slot);
    endcase
  endfunction

  function automatic logic [31:0] entry_marker(input logic hdl, input logic on_proc);
    if (hdl) return MK_HDL;
    return on_proc ? MK_THRP : MK_THRM;
  endfunction

  function automatic logic [31:0] word_addr(input logic [31:0] base, input logic [31:0] k);
    return base + (k << 2);
  endfunction
endpackage

// File: rtl/exc_marker_dec.sv
module exc_marker_dec (
  input  logic [31:0] val,
  output logic        is_marker,
  output logic        marker_ok,
  output logic        to_handler,
  output logic        to_proc
);
  always_comb begin
    is_marker  = &val[31:5];
    marker_ok  = is_marker && (val[4:0] == 5'h11 || val[4:0] == 5'h19 || val[4:0] == 5'h1D);
    to_handler = !val[3];
    to_proc    = val[2];
  end
endmodule

// File: rtl/exc_beat_cnt.sv
module exc_beat_cnt #(
  parameter int W    = 3,
  parameter int LAST = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] idx,
  output logic         last
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) idx <= '0;
    else if (step)     idx <= last ? '0 : idx + 1'b1;
  end
  assign last = (idx == W'(LAST));
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int          NUM_W   = 5,
  parameter logic [31:0] VT_BASE = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_req,
  input  logic [NUM_W-1:0] exc_num,
  input  logic             in_handler,
  input  logic             on_psp,
  input  logic [31:0]      msp,
  input  logic [31:0]      psp,
  input  logic [31:0]      cur_pc,
  input  logic [31:0]      cur_psr,
  input  logic             pc_wr_valid,
  input  logic [31:0]      pc_wr_data,
  output logic [3:0]       rf_raddr,
  input  logic [31:0]      rf_rdata,
  output logic             rf_we,
  output logic [3:0]       rf_waddr,
  output logic [31:0]      rf_wdata,
  output logic             sp_we,
  output logic             sp_sel,
  output logic [31:0]      sp_wdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ready,
  input  logic [31:0]      mem_rdata,
  output logic             busy,
  output logic             branch_take,
  output logic             ret_err,
  output logic             vec_valid,
  output logic [31:0]      vec_pc,
  output logic             ret_valid,
  output logic [31:0]      ret_pc,
  output logic [31:0]      ret_psr,
  output logic             ret_handler,
  output logic             ret_psp
);
  seq_state_t       st_q;
  logic [31:0]      base_q, code_q, pc_q, psr_q, ret_pc_q;
  logic [NUM_W-1:0] num_q;
  logic             frame_proc_q, ret_hdl_q, ret_proc_q;

  logic             is_marker, marker_ok, dec_hdl, dec_proc;
  logic [IDX_W-1:0] idx;
  logic             last;

  // Named internal events
  logic in_idle, hs, take_ret, tail_go, pop_go, enter_go;
  logic push_done, pop_done, vec_done, cnt_clr, cnt_step;

  exc_marker_dec u_dec (
    .val(pc_wr_data), .is_marker(is_marker), .marker_ok(marker_ok),
    .to_handler(dec_hdl), .to_proc(dec_proc)
  );

  exc_beat_cnt #(.W(IDX_W), .LAST(FRAME_WORDS - 1)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .step(cnt_step), .idx(idx), .last(last)
  );

  always_comb begin
    in_idle   = (st_q == ST_IDLE);
    hs        = mem_req && mem_ready;
    take_ret  = in_idle && pc_wr_valid && marker_ok;
    tail_go   = take_ret && exc_req;
    pop_go    = take_ret && !exc_req;
    enter_go  = in_idle && exc_req && !take_ret;
    push_done = (st_q == ST_PUSH) && hs && last;
    pop_done  = (st_q == ST_POP) && hs && last;
    vec_done  = (st_q == ST_VEC) && hs;
    cnt_clr   = in_idle || (st_q == ST_VEC);
    cnt_step  = hs && (st_q == ST_PUSH || st_q == ST_POP);
  end

  // Memory side
  always_comb begin
    busy      = !in_idle;
    mem_req   = !in_idle;
    mem_we    = (st_q == ST_PUSH);
    mem_addr  = (st_q == ST_VEC) ? word_addr(VT_BASE, 32'(num_q)) : word_addr(base_q, 32'(idx));
    rf_raddr  = frame_reg(idx);
    if (idx == IDX_W'(6))      mem_wdata = pc_q;
    else if (idx == IDX_W'(7)) mem_wdata = psr_q;
    else                       mem_wdata = rf_rdata;
  end

  // Register file and stack pointer side
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = '0;
    rf_wdata = '0;
    if (tail_go) begin
      rf_we = 1'b1; rf_waddr = LR_IDX; rf_wdata = pc_wr_data;
    end else if (push_done) begin
      rf_we = 1'b1; rf_waddr = LR_IDX; rf_wdata = code_q;
    end else if ((st_q == ST_POP) && hs && (idx < IDX_W'(6))) begin
      rf_we = 1'b1; rf_waddr = frame_reg(idx); rf_wdata = mem_rdata;
    end
    sp_we    = push_done || pop_done;
    sp_sel   = push_done ? frame_proc_q : ret_proc_q;
    sp_wdata = push_done ? base_q : base_q + 32'(FRAME_BYTES);
  end

  // Core side
  always_comb begin
    branch_take = in_idle && pc_wr_valid && !is_marker;
    ret_err     = in_idle && pc_wr_valid && is_marker && !marker_ok;
    vec_valid   = vec_done;
    vec_pc      = mem_rdata;
    ret_valid   = pop_done;
    ret_pc      = ret_pc_q;
    ret_psr     = mem_rdata;
    ret_handler = ret_hdl_q;
    ret_psp     = ret_proc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      base_q       <= '0;
      code_q       <= '0;
      pc_q         <= '0;
      psr_q        <= '0;
      ret_pc_q     <= '0;
      num_q        <= '0;
      frame_proc_q <= 1'b0;
      ret_hdl_q    <= 1'b0;
      ret_proc_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (tail_go) begin
            num_q  <= exc_num;
            code_q <= pc_wr_data;
            st_q   <= ST_VEC;
          end else if (pop_go) begin
            base_q     <= dec_proc ? psp : msp;
            ret_hdl_q  <= dec_hdl;
            ret_proc_q <= dec_proc;
            st_q       <= ST_POP;
          end else if (enter_go) begin
            frame_proc_q <= on_psp && !in_handler;
            base_q       <= ((on_psp && !in_handler) ? psp : msp) - 32'(FRAME_BYTES);
            num_q        <= exc_num;
            code_q       <= entry_marker(in_handler, on_psp);
            pc_q         <= cur_pc;
            psr_q        <= cur_psr;
            st_q         <= ST_PUSH;
          end
        end
        ST_PUSH: if (push_done) st_q <= ST_VEC;
        ST_VEC:  if (vec_done)  st_q <= ST_IDLE;
        ST_POP: begin
          if (hs && idx == IDX_W'(6)) ret_pc_q <= mem_rdata;
          if (pop_done) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_req,
  input logic        pc_wr_valid,
  input logic [31:0] pc_wr_data,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ready,
  input logic        busy,
  input logic        branch_take,
  input logic        ret_err,
  input logic        vec_valid,
  input logic        ret_valid,
  input logic        sp_we,
  input logic [31:0] sp_wdata,
  input logic        rf_we,
  input logic [3:0]  rf_waddr,
  input logic [31:0] rf_wdata
);
  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r11_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  a_r6_marker_no_branch: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_valid && (&pc_wr_data[31:5]) |-> !branch_take);

  a_r8_sp_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> sp_we && (sp_wdata == mem_addr + 32'd4));

  a_r4_link_on_push_end: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we && mem_we |-> rf_we && (rf_waddr == 4'd14) && (&rf_wdata[31:5]));

  a_r9_err_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err |=> !busy);

  a_r10_tail_goes_to_vector: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && pc_wr_valid && (&pc_wr_data[31:5]) && exc_req &&
    (pc_wr_data[4:0] == 5'h11 || pc_wr_data[4:0] == 5'h19 || pc_wr_data[4:0] == 5'h1D)
    |=> mem_req && !mem_we);

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ret_valid, vec_valid, ret_err}));
endmodule

bind exc_seq exc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .pc_wr_valid(pc_wr_valid),
  .pc_wr_data(pc_wr_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready), .busy(busy), .branch_take(branch_take),
  .ret_err(ret_err), .vec_valid(vec_valid), .ret_valid(ret_valid), .sp_we(sp_we),
  .sp_wdata(sp_wdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
);

// File: tb/exc_seq_bench.sv
module exc_seq_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, exc_req, in_handler, on_psp, pc_wr_valid, stall_on;
  logic [4:0]  exc_num;
  logic [31:0] cur_pc, cur_psr, pc_wr_data;
  logic [31:0] msp_m, psp_m;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, sp_wdata, mem_addr, mem_wdata, mem_rdata;
  logic [31:0] vec_pc, ret_pc, ret_psr;
  logic        rf_we, sp_we, sp_sel, mem_req, mem_we, mem_ready, busy;
  logic        branch_take, ret_err, vec_valid, ret_valid, ret_handler, ret_psp;

  logic [31:0] mem [0:255];
  logic [31:0] rf  [0:15];
  int          hs_cnt = 0;
  logic [3:0]  cyc = '0;
  int          n_chk = 0, n_err = 0;

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_ready = !stall_on || (cyc[1:0] == 2'b00) || (cyc[1:0] == 2'b11);

  exc_seq u_exc_seq (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_num(exc_num),
    .in_handler(in_handler), .on_psp(on_psp), .msp(msp_m), .psp(psp_m),
    .cur_pc(cur_pc), .cur_psr(cur_psr), .pc_wr_valid(pc_wr_valid), .pc_wr_data(pc_wr_data),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .sp_we(sp_we), .sp_sel(sp_sel), .sp_wdata(sp_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .branch_take(branch_take),
    .ret_err(ret_err), .vec_valid(vec_valid), .vec_pc(vec_pc), .ret_valid(ret_valid),
    .ret_pc(ret_pc), .ret_psr(ret_psr), .ret_handler(ret_handler), .ret_psp(ret_psp)
  );

  // Memory, register file and stack pointer models
  always @(posedge clk) begin
    cyc <= cyc + 1'b1;
    if (mem_req && mem_ready) begin
      hs_cnt <= hs_cnt + 1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (sp_we) begin
      if (sp_sel) psp_m <= sp_wdata;
      else        msp_m <= sp_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] got_vec, got_pc, got_psr;
  logic        got_hdl, got_proc;

  task automatic wait_vec();
    bit seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (vec_valid) begin seen = 1; got_vec = vec_pc; exc_req = 1'b0; end
    end
    chk("R5 vector pulse seen", 32'(seen), 32'd1);
  endtask

  task automatic wait_ret();
    bit seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (ret_valid) begin
        seen = 1; got_pc = ret_pc; got_psr = ret_psr; got_hdl = ret_handler; got_proc = ret_psp;
      end
    end
    chk("R8 done pulse seen", 32'(seen), 32'd1);
  endtask

  task automatic pc_write(input logic [31:0] v, input logic exp_branch);
    @(negedge clk);
    pc_wr_valid = 1'b1; pc_wr_data = v;
    #1 chk("R6 branch_take", 32'(branch_take), 32'(exp_branch));
    @(negedge clk);
    pc_wr_valid = 1'b0;
  endtask

  function automatic logic [31:0] reg_val(input int row, input int r);
    return 32'hC000_0000 | 32'(row << 8) | 32'(r);
  endfunction

  function automatic int frame_reg_idx(input int slot);
    return (slot == 4) ? 12 : (slot == 5) ? 14 : slot;
  endfunction

  // {stall, handler, on_psp, exc_num[4:0], expected marker}
  localparam logic [39:0] ROWS [4] = '{
    {1'b0, 1'b0, 1'b0, 5'd3,  32'hFFFF_FFF9},
    {1'b1, 1'b0, 1'b1, 5'd7,  32'hFFFF_FFFD},
    {1'b1, 1'b1, 1'b0, 5'd12, 32'hFFFF_FFF1},
    {1'b0, 1'b0, 1'b1, 5'd31, 32'hFFFF_FFFD}
  };

  logic [31:0] base_e;
  int          hs0;

  task automatic do_entry(input int row, input logic hdl, input logic proc, input logic [4:0] num,
                          input logic [31:0] mk);
    @(negedge clk);
    for (int r = 0; r < 16; r++) rf[r] = reg_val(row, r);
    in_handler = hdl; on_psp = proc; exc_num = num;
    cur_pc  = 32'h0800_0000 + 32'(row * 64);
    cur_psr = 32'h0100_0000 | 32'(row);
    base_e  = ((proc && !hdl) ? psp_m : msp_m) - 32'd32;
    hs0 = hs_cnt;
    exc_req = 1'b1;
    wait_vec();
    @(negedge clk);
    chk("R5 handler address", got_vec, 32'h1000 + 32'(num) * 32'h10);
    chk("R3 nine handshakes on entry", 32'(hs_cnt - hs0), 32'd9);
    chk("R11 busy low after entry", 32'(busy), 32'd0);
    for (int s = 0; s < 8; s++)
      chk("R2 frame word", mem[base_e[9:2] + 8'(s)],
          (s < 6) ? reg_val(row, frame_reg_idx(s)) : (s == 6) ? cur_pc : cur_psr);
    chk("R4 link register marker", rf[14], mk);
    chk("R4 stack pointer lowered", (proc && !hdl) ? psp_m : msp_m, base_e);
  endtask

  task automatic do_return(input int row, input logic [31:0] mk, input logic [31:0] epc,
                           input logic [31:0] epsr);
    logic [31:0] base_r;
    base_r = mk[2] ? psp_m : msp_m;
    rf[0] = 0; rf[1] = 0; rf[2] = 0; rf[3] = 0; rf[12] = 0; rf[14] = 0;
    hs0 = hs_cnt;
    pc_write(mk, 1'b0);
    wait_ret();
    @(negedge clk);
    chk("R8 resume address", got_pc, epc);
    chk("R8 status word", got_psr, epsr);
    chk("R8 handler flag", 32'(got_hdl), 32'(mk == 32'hFFFF_FFF1));
    chk("R8 process flag", 32'(got_proc), 32'(mk == 32'hFFFF_FFFD));
    chk("R8 stack pointer raised", mk[2] ? psp_m : msp_m, base_r + 32'd32);
    chk("R7 eight reads", 32'(hs_cnt - hs0), 32'd8);
    for (int s = 0; s < 6; s++)
      chk("R7 register restored", rf[frame_reg_idx(s)], reg_val(row, frame_reg_idx(s)));
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = (k < 32) ? 32'h1000 + 32'(k) * 32'h10 : 32'h0;
    for (int r = 0; r < 16; r++) rf[r] = 32'h0;
    rst_n = 0; exc_req = 0; in_handler = 0; on_psp = 0; exc_num = '0;
    cur_pc = '0; cur_psr = '0; pc_wr_valid = 0; pc_wr_data = '0; stall_on = 0;
    msp_m = 32'h200; psp_m = 32'h300;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 no request after reset", 32'(mem_req), 32'd0);

    // Table-driven entry and return
    for (int row = 0; row < 4; row++) begin
      logic [39:0] v;
      v = ROWS[row];
      stall_on = v[39];
      do_entry(row, v[38], v[37], v[36:32], v[31:0]);
      do_return(row, v[31:0], cur_pc, cur_psr);
    end
    stall_on = 0;

    // R6: ordinary branches, including one just outside the marker range
    hs0 = hs_cnt;
    pc_write(32'h0000_2000, 1'b1);
    pc_write(32'hFFFF_FFC1, 1'b1);
    chk("R6 branch causes no access", 32'(hs_cnt - hs0), 32'd0);

    // R9: unsupported marker
    @(negedge clk);
    pc_wr_valid = 1'b1; pc_wr_data = 32'hFFFF_FFF5;
    #1 chk("R9 error pulse", 32'(ret_err), 32'd1);
    @(negedge clk);
    pc_wr_valid = 1'b0;
    chk("R9 stays idle", 32'(busy), 32'd0);
    chk("R9 no access", 32'(hs_cnt - hs0), 32'd0);

    // R10: waiting exception at return skips restore
    stall_on = 1;
    do_entry(5, 1'b0, 1'b1, 5'd5, 32'hFFFF_FFFD);
    rf[14] = 32'h0;
    @(negedge clk);
    hs0 = hs_cnt;
    exc_num = 5'd9; exc_req = 1'b1;
    pc_wr_valid = 1'b1; pc_wr_data = 32'hFFFF_FFFD;
    #1 chk("R10 no branch", 32'(branch_take), 32'd0);
    @(negedge clk);
    pc_wr_valid = 1'b0;
    wait_vec();
    @(negedge clk);
    chk("R10 new handler address", got_vec, 32'h1000 + 32'd9 * 32'h10);
    chk("R10 single access", 32'(hs_cnt - hs0), 32'd1);
    chk("R10 link rewritten", rf[14], 32'hFFFF_FFFD);
    chk("R10 stack untouched", psp_m, base_e);
    do_return(5, 32'hFFFF_FFFD, 32'h0800_0000 + 32'd320, 32'h0100_0005);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule